// File: doc/BRIEF.md
# Processor Bus Cycle Terminator

This block answers the bus cycles of a 32-bit processor for one memory port that sits behind an address decoder. When the decoder selects the board and the processor drops its address strobe, the block waits out a fixed number of wait states and then ends the cycle once the memory reports ready. It ends the cycle in one of two ways, chosen by a mode pin: asynchronous, where both port-size acknowledge lines go low and stay low until the strobe is negated, or synchronous, where a single-clock terminate pulse is given. In synchronous mode a read that carries a line-fill request is answered with a burst acknowledge and four longword beats. The beats wrap inside a 16-byte line, starting at the requested longword.

On writes the block turns the transfer size and the byte offset into four byte-lane write enables. Reads always return the full port and enable no lanes. A read output enable stays high from termination until the data strobe goes high. A bus error, or loss of the select, releases every termination line in the same cycle and aborts the cycle. All pins are plain level or strobe controls. There is no data stream and no back-pressure path. The only flow control is `mem_ready`, which holds the cycle in its wait state.

Top module: `bterm_top`

## Requirements
- R1: While reset is held and after reset, with no cycle running, `async_ack_n` is 2'b11, `sync_ack_n` and `burst_ack_n` are 1, and `lane_we` and `read_oe` are 0.
- R2: Asynchronous mode (`sync_mode`=0): counting the edge that first samples the strobe low and the select high as edge k, both bits of `async_ack_n` go low together after edge k+WAIT_CYC+2 if `mem_ready` is high. They stay low until the edge that samples `addr_strobe_n` high, and are released after that edge.
- R3: Synchronous mode without a burst: `sync_ack_n` is low for exactly one clock, after edge k+WAIT_CYC+1 if `mem_ready` is high. The two termination kinds are never active together.
- R4: Termination happens at the first edge that samples `mem_ready` high once the wait count has run out. Each earlier edge that samples it low delays the termination by one clock.
- R5: A synchronous read whose `burst_req_n` is low at cycle start gets four beats. `burst_ack_n` goes low with the first beat and stays low until the fourth is done. `beat_idx` runs line_idx, line_idx+1, ... modulo 4, and each beat after the first waits for `mem_ready`.
- R6: `burst_req_n` is ignored in asynchronous mode and on writes: a single termination is given and `burst_ack_n` stays high.
- R7: On a write, `lane_we` is high from cycle start to termination. `lane_we[3]` is byte offset 0 and `lane_we[0]` is byte offset 3. Size codes on `xfer_size` are 01 byte, 10 word, 11 three bytes, 00 four bytes. Lane 3-j is enabled when offset <= j < offset+size, clipped at the port end. Reads enable no lane.
- R8: On a read, `read_oe` is high from termination until `data_strobe_n` goes high, and it falls in the same cycle as that strobe.
- R9: While `fault_n` is low, every termination output is released and `lane_we`/`read_oe` are 0 in the same cycle. The cycle then ends with no termination, even if `mem_ready` arrives, until the strobe is negated.
- R10: While `board_sel` is low, every termination output is released in the same cycle, and an active cycle is abandoned.
- R11: A strobe seen while `board_sel` is low starts no cycle, and nothing is terminated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_mode | input | 1 | 1 selects synchronous termination, 0 asynchronous; sampled at cycle start |
| board_sel | input | 1 | Address decoder hit for this port |
| addr_strobe_n | input | 1 | Address strobe, active low; marks a bus cycle |
| data_strobe_n | input | 1 | Data strobe, active low |
| read_cyc | input | 1 | 1 for a read cycle, 0 for a write |
| xfer_size | input | 2 | Transfer size code (see R7) |
| byte_off | input | OW (2) | Low address bits, byte offset in the port |
| line_idx | input | BW (2) | Longword index inside the 16-byte line |
| burst_req_n | input | 1 | Line-fill burst request, active low |
| fault_n | input | 1 | Bus error, active low |
| mem_ready | input | 1 | Memory can complete the current transfer |
| async_ack_n | output | 2 | Port-size acknowledge pair, active low |
| sync_ack_n | output | 1 | Synchronous terminate, active low |
| burst_ack_n | output | 1 | Burst acknowledge, active low |
| lane_we | output | LANES (4) | Byte-lane write enables |
| read_oe | output | 1 | Read data drive enable |
| beat_idx | output | BW (2) | Longword index of the current transfer |

## Verification
The hardest situations to reach from the ports are a bus error and a loss of select that land while a cycle is parked or holding its acknowledge. The termination logic otherwise leaves those states within a few clocks. The stimulus keeps `mem_ready` low to park a write in its wait state, then raises `fault_n`'s error and later supplies ready, and checks that no termination ever appears. A separate asynchronous cycle keeps its strobe low after the acknowledge so that the select can be dropped while the acknowledge is held. Bursts start from several line offsets and include a ready delay, which exercises the wrap of the beat index.

// File: rtl/bterm_pkg.sv
package bterm_pkg;

  typedef enum logic [1:0] {
    SZ_LONG   = 2'b00,
    SZ_BYTE   = 2'b01,
    SZ_WORD   = 2'b10,
    SZ_TRIPLE = 2'b11
  } xfer_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_AHOLD,
    ST_SBEAT,
    ST_BURST,
    ST_DONE
  } cyc_state_e;

  // Number of bytes moved for a size code; code 00 means a full longword.
  function automatic int size_bytes(input logic [1:0] code);
    xfer_size_e s;
    s = xfer_size_e'(code);
    case (s)
      SZ_BYTE:   return 1;
      SZ_WORD:   return 2;
      SZ_TRIPLE: return 3;
      default:   return 4;
    endcase
  endfunction

endpackage

// File: rtl/bterm_delay.sv
module bterm_delay #(
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/bterm_beats.sv
module bterm_beats #(
  parameter int unsigned LINE_BEATS = 4,
  parameter int unsigned BW         = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] start_idx,
  input  logic          step,
  output logic [BW-1:0] idx,
  output logic          last
);
  logic [BW-1:0] idx_q;
  logic [BW-1:0] done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      done_q <= '0;
    end else if (load) begin
      idx_q  <= start_idx;
      done_q <= '0;
    end else if (step) begin
      idx_q  <= idx_q + 1'b1;
      done_q <= done_q + 1'b1;
    end
  end

  assign idx  = idx_q;
  assign last = (done_q == BW'(LINE_BEATS - 1));
endmodule

// File: rtl/bterm_lanes.sv
module bterm_lanes import bterm_pkg::*; #(
  parameter int unsigned LANES = 4,
  parameter int unsigned OW    = 2
) (
  input  logic [1:0]       size_code,
  input  logic [OW-1:0]    offset,
  output logic [LANES-1:0] mask
);
  int off_i;
  int end_i;

  assign off_i = int'(offset);
  assign end_i = off_i + size_bytes(size_code);

  // Byte offset j lives on lane LANES-1-j (big-endian port).
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign mask[LANES-1-j] = (j >= off_i) && (j < end_i);
  end
endmodule

// File: rtl/bterm_ctrl.sv
module bterm_ctrl import bterm_pkg::*; #(
  parameter int unsigned WAIT_CYC = 1,
  parameter int unsigned CW       = 3,
  parameter int unsigned OW       = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_mode,
  input  logic          board_sel,
  input  logic          addr_strobe_n,
  input  logic          data_strobe_n,
  input  logic          read_cyc,
  input  logic          burst_req_n,
  input  logic          fault_n,
  input  logic          mem_ready,
  input  logic [1:0]    xfer_size,
  input  logic [OW-1:0] byte_off,
  input  logic          wait_done,
  input  logic          beat_last,
  output logic          dly_load,
  output logic [CW-1:0] dly_val,
  output logic          beat_load,
  output logic          beat_step,
  output logic          term_async,
  output logic          term_sync,
  output logic          burst_on,
  output logic          write_on,
  output logic          oe_on,
  output logic [1:0]    size_q,
  output logic [OW-1:0] off_q
);
  cyc_state_e st, st_n;
  logic mode_q, read_q, breq_q, beat_q, oe_q;
  logic start, abort, ready_go, entering;

  assign start    = (st == ST_IDLE) && !addr_strobe_n && board_sel && fault_n;
  assign abort    = (st != ST_IDLE) && (!fault_n || !board_sel);
  assign ready_go = wait_done && mem_ready;
  assign entering = (st == ST_WAIT) && !addr_strobe_n && ready_go && !abort;

  always_comb begin
    st_n      = st;
    dly_load  = 1'b0;
    beat_load = 1'b0;
    beat_step = 1'b0;
    // Async ends one clock later than sync for the same wait count.
    dly_val   = sync_mode ? CW'(WAIT_CYC) : CW'(WAIT_CYC + 1);
    if (abort) begin
      st_n = ST_DONE;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st_n      = ST_WAIT;
          dly_load  = 1'b1;
          beat_load = 1'b1;
        end
        ST_WAIT: begin
          if (addr_strobe_n)  st_n = ST_IDLE;
          else if (ready_go)  st_n = !mode_q ? ST_AHOLD :
                                     (breq_q && read_q) ? ST_BURST : ST_SBEAT;
        end
        ST_AHOLD: if (addr_strobe_n) st_n = ST_IDLE;
        ST_SBEAT: st_n = ST_DONE;
        ST_BURST: if (beat_q) begin
          beat_step = 1'b1;
          if (beat_last) st_n = ST_DONE;
        end
        ST_DONE:  if (addr_strobe_n) st_n = ST_IDLE;
        default:  st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      mode_q <= 1'b0;
      read_q <= 1'b1;
      breq_q <= 1'b0;
      beat_q <= 1'b0;
      oe_q   <= 1'b0;
      size_q <= '0;
      off_q  <= '0;
    end else begin
      st <= st_n;
      if (start) begin
        mode_q <= sync_mode;
        read_q <= read_cyc;
        breq_q <= !burst_req_n;
        size_q <= xfer_size;
        off_q  <= byte_off;
      end
      beat_q <= (st_n == ST_BURST) && ((st == ST_WAIT) || mem_ready);
      if (abort || st_n == ST_IDLE) oe_q <= 1'b0;
      else if (entering && read_q)  oe_q <= 1'b1;
    end
  end

  assign term_async = (st == ST_AHOLD);
  assign term_sync  = (st == ST_SBEAT) || ((st == ST_BURST) && beat_q);
  assign burst_on   = (st == ST_BURST);
  assign write_on   = !read_q && ((st == ST_WAIT) || (st == ST_AHOLD) || (st == ST_SBEAT));
  assign oe_on      = oe_q && !data_strobe_n;
endmodule

// File: rtl/bterm_top.sv
module bterm_top #(
  parameter int unsigned WAIT_CYC   = 1,
  parameter int unsigned LINE_BEATS = 4,
  parameter int unsigned LANES      = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sync_mode,
  input  logic                          board_sel,
  input  logic                          addr_strobe_n,
  input  logic                          data_strobe_n,
  input  logic                          read_cyc,
  input  logic [1:0]                    xfer_size,
  input  logic [$clog2(LANES)-1:0]      byte_off,
  input  logic [$clog2(LINE_BEATS)-1:0] line_idx,
  input  logic                          burst_req_n,
  input  logic                          fault_n,
  input  logic                          mem_ready,
  output logic [1:0]                    async_ack_n,
  output logic                          sync_ack_n,
  output logic                          burst_ack_n,
  output logic [LANES-1:0]              lane_we,
  output logic                          read_oe,
  output logic [$clog2(LINE_BEATS)-1:0] beat_idx
);
  localparam int unsigned CW = $clog2(WAIT_CYC + 2) + 1;
  localparam int unsigned BW = $clog2(LINE_BEATS);
  localparam int unsigned OW = $clog2(LANES);

  logic          dly_load, wait_done, beat_load, beat_step, beat_last;
  logic [CW-1:0] dly_val;
  logic          term_async, term_sync, burst_on, write_on, oe_on;
  logic [1:0]    size_q;
  logic [OW-1:0] off_q;
  logic [LANES-1:0] mask;
  logic          released;

  bterm_ctrl #(.WAIT_CYC(WAIT_CYC), .CW(CW), .OW(OW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .board_sel(board_sel),
    .addr_strobe_n(addr_strobe_n), .data_strobe_n(data_strobe_n),
    .read_cyc(read_cyc), .burst_req_n(burst_req_n), .fault_n(fault_n),
    .mem_ready(mem_ready), .xfer_size(xfer_size), .byte_off(byte_off),
    .wait_done(wait_done), .beat_last(beat_last), .dly_load(dly_load),
    .dly_val(dly_val), .beat_load(beat_load), .beat_step(beat_step),
    .term_async(term_async), .term_sync(term_sync), .burst_on(burst_on),
    .write_on(write_on), .oe_on(oe_on), .size_q(size_q), .off_q(off_q)
  );

  bterm_delay #(.CW(CW)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(dly_load), .load_val(dly_val), .done(wait_done)
  );

  bterm_beats #(.LINE_BEATS(LINE_BEATS), .BW(BW)) u_beats (
    .clk(clk), .rst_n(rst_n), .load(beat_load), .start_idx(line_idx),
    .step(beat_step), .idx(beat_idx), .last(beat_last)
  );

  bterm_lanes #(.LANES(LANES), .OW(OW)) u_lanes (
    .size_code(size_q), .offset(off_q), .mask(mask)
  );

  // Release every termination line at once on bus error or deselect.
  assign released    = !board_sel || !fault_n;
  assign async_ack_n = (term_async && !released) ? 2'b00 : 2'b11;
  assign sync_ack_n  = !(term_sync && !released);
  assign burst_ack_n = !(burst_on && !released);
  assign lane_we     = (write_on && !released) ? mask : '0;
  assign read_oe     = oe_on && !released;
endmodule

// File: rtl/bterm_chk.sv
module bterm_chk #(
  parameter int unsigned LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             board_sel,
  input logic             fault_n,
  input logic [1:0]       async_ack_n,
  input logic             sync_ack_n,
  input logic             burst_ack_n,
  input logic [LANES-1:0] lane_we,
  input logic             read_oe
);
  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_idle_chk: assert (async_ack_n == 2'b11 && sync_ack_n && burst_ack_n
                              && lane_we == '0 && !read_oe);
    end
  end

  // R9
  fault_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> (async_ack_n == 2'b11 && sync_ack_n && burst_ack_n && lane_we == '0 && !read_oe));

  // R10
  desel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !board_sel |-> (async_ack_n == 2'b11 && sync_ack_n && burst_ack_n && lane_we == '0 && !read_oe));

  // R2
  both_lanes_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (async_ack_n != 2'b11) |-> (async_ack_n == 2'b00));

  // R3
  single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sync_ack_n) && burst_ack_n) |=> sync_ack_n);

  // R3
  one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(async_ack_n == 2'b00 && !sync_ack_n));

  // R5
  burst_with_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(burst_ack_n) |-> !sync_ack_n);
endmodule

bind bterm_top bterm_chk #(.LANES(LANES)) i_chk (
  .clk(clk), .rst_n(rst_n), .board_sel(board_sel), .fault_n(fault_n),
  .async_ack_n(async_ack_n), .sync_ack_n(sync_ack_n), .burst_ack_n(burst_ack_n),
  .lane_we(lane_we), .read_oe(read_oe)
);

// File: tb/test_bterm_top.sv
module test_bterm_top;
  localparam int W = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_mode = 1'b0, board_sel = 1'b0, as_n = 1'b1, ds_n = 1'b1, rd = 1'b1;
  logic [1:0] sz = 2'b00, off = 2'b00, lw = 2'b00;
  logic breq_n = 1'b1, fault_n = 1'b1, ready = 1'b0;
  logic [1:0] async_ack_n;
  logic sync_ack_n, burst_ack_n, read_oe;
  logic [3:0] lane_we;
  logic [1:0] beat_idx;

  int n_tests = 0;
  int n_fail = 0;
  bit timed_out = 1'b0;

  typedef struct {
    bit         is_sync;
    logic [1:0] beat;
    bit         burst;
    logic [3:0] lanes;
    bit         oe;
    int         lat;
    string      req;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  bterm_top #(.WAIT_CYC(W)) i_bterm_top (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .board_sel(board_sel),
    .addr_strobe_n(as_n), .data_strobe_n(ds_n), .read_cyc(rd), .xfer_size(sz),
    .byte_off(off), .line_idx(lw), .burst_req_n(breq_n), .fault_n(fault_n),
    .mem_ready(ready), .async_ack_n(async_ack_n), .sync_ack_n(sync_ack_n),
    .burst_ack_n(burst_ack_n), .lane_we(lane_we), .read_oe(read_oe), .beat_idx(beat_idx)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_mask(input logic [1:0] s, input logic [1:0] o);
    int n;
    logic [3:0] m;
    n = (s == 2'b00) ? 4 : int'(s);
    for (int j = 0; j < 4; j++) m[3-j] = (j >= int'(o)) && (j < int'(o) + n);
    return m;
  endfunction

  // Scoreboard monitor: every termination seen at the ports pops one expected item.
  initial begin
    int lat = 0;
    logic [1:0] prev_async = 2'b11;
    forever begin
      @(posedge clk);
      if (!as_n) lat++; else lat = 0;
      #2;
      if (rst_n) begin
        bit s_ev, a_ev;
        s_ev = !sync_ack_n;
        a_ev = (async_ack_n == 2'b00) && (prev_async != 2'b00);
        if (s_ev || a_ev) begin
          if (q.size() == 0) begin
            chk(1'b0, "R9", "unexpected termination", 1, 0);
          end else begin
            exp_t e;
            e = q.pop_front();
            chk(s_ev == e.is_sync, e.req, "termination kind sync", int'(s_ev), int'(e.is_sync));
            chk(lat == e.lat, e.req, "termination latency", lat, e.lat);
            chk(beat_idx == e.beat, e.req, "beat index", int'(beat_idx), int'(e.beat));
            chk(!burst_ack_n == e.burst, e.req, "burst ack", int'(!burst_ack_n), int'(e.burst));
            chk(lane_we == e.lanes, e.req, "lane enables", int'(lane_we), int'(e.lanes));
            chk(read_oe == e.oe, e.req, "read enable", int'(read_oe), int'(e.oe));
          end
        end
        prev_async = async_ack_n;
      end
    end
  end

  // Driver: pushes expected items then plays one full bus cycle.
  task automatic run_cyc(input bit smode, input bit rdc, input logic [1:0] s, input logic [1:0] o,
                         input logic [1:0] l, input bit breq, input int d, input string req);
    int l0;
    bit burst;
    int nb;
    l0 = smode ? W + 1 : W + 2;
    burst = smode && rdc && breq;
    nb = burst ? 4 : 1;
    for (int i = 0; i < nb; i++) begin
      exp_t e;
      e.is_sync = smode;
      e.beat    = l + 2'(i);
      e.burst   = burst;
      e.lanes   = rdc ? 4'b0000 : exp_mask(s, o);
      e.oe      = rdc;
      e.lat     = l0 + d + 1 + i;
      e.req     = req;
      q.push_back(e);
    end
    @(negedge clk);
    sync_mode = smode; rd = rdc; sz = s; off = o; lw = l; breq_n = !breq;
    board_sel = 1'b1; as_n = 1'b0; ds_n = 1'b0; ready = (d == 0);
    repeat (l0 + d) @(negedge clk);
    ready = 1'b1;
    repeat (nb) @(negedge clk);
    as_n = 1'b1; ds_n = 1'b1; ready = 1'b0; breq_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic stimulus;
    exp_t e;
    repeat (3) @(negedge clk);
    chk(async_ack_n == 2'b11 && sync_ack_n && burst_ack_n, "R1", "acks in reset", int'(async_ack_n), 3);
    chk(lane_we == 4'b0 && !read_oe, "R1", "lanes in reset", int'(lane_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    board_sel = 1'b1;
    #1;
    chk(async_ack_n == 2'b11 && sync_ack_n && burst_ack_n, "R1", "acks idle", int'(async_ack_n), 3);

    run_cyc(0, 1, 2'b00, 2'b00, 2'd2, 0, 0, "R2");
    run_cyc(1, 1, 2'b00, 2'b00, 2'd1, 0, 0, "R3");
    run_cyc(0, 0, 2'b01, 2'b11, 2'd0, 0, 0, "R7");
    run_cyc(1, 0, 2'b10, 2'b01, 2'd0, 0, 0, "R7");
    run_cyc(1, 0, 2'b00, 2'b10, 2'd3, 0, 0, "R7");
    run_cyc(0, 0, 2'b11, 2'b00, 2'd0, 0, 0, "R7");
    run_cyc(1, 0, 2'b11, 2'b01, 2'd0, 0, 0, "R7");
    run_cyc(1, 0, 2'b01, 2'b00, 2'd0, 0, 0, "R7");
    run_cyc(1, 1, 2'b00, 2'b00, 2'd2, 1, 0, "R5");
    run_cyc(1, 1, 2'b01, 2'b00, 2'd3, 1, 1, "R5");
    run_cyc(0, 1, 2'b00, 2'b00, 2'd1, 1, 0, "R6");
    run_cyc(1, 0, 2'b00, 2'b00, 2'd1, 1, 0, "R6");
    run_cyc(0, 1, 2'b00, 2'b00, 2'd0, 0, 2, "R4");
    run_cyc(1, 0, 2'b10, 2'b10, 2'd0, 0, 3, "R4");

    // R8: read enable follows the data strobe while the ack is held.
    e.is_sync = 0; e.beat = 2'd0; e.burst = 0; e.lanes = 4'b0; e.oe = 1; e.lat = W + 3; e.req = "R8";
    q.push_back(e);
    @(negedge clk);
    sync_mode = 0; rd = 1; lw = 2'd0; board_sel = 1; as_n = 0; ds_n = 0; ready = 1;
    repeat (W + 3) @(negedge clk);
    chk(read_oe == 1'b1, "R8", "read enable before strobe negation", int'(read_oe), 1);
    ds_n = 1'b1;
    #1;
    chk(read_oe == 1'b0, "R8", "read enable after strobe negation", int'(read_oe), 0);
    @(negedge clk);
    chk(async_ack_n == 2'b00, "R2", "ack held while strobe low", int'(async_ack_n), 0);
    as_n = 1'b1; ready = 0;
    @(negedge clk);
    chk(async_ack_n == 2'b11, "R2", "ack released after strobe", int'(async_ack_n), 3);
    @(negedge clk);

    // R10: deselect while an async ack is held.
    e.is_sync = 0; e.beat = 2'd0; e.burst = 0; e.lanes = exp_mask(2'b00, 2'b00); e.oe = 0;
    e.lat = W + 3; e.req = "R10";
    q.push_back(e);
    @(negedge clk);
    sync_mode = 0; rd = 0; sz = 2'b00; off = 2'b00; board_sel = 1; as_n = 0; ds_n = 0; ready = 1;
    repeat (W + 3) @(negedge clk);
    board_sel = 1'b0;
    #1;
    chk(async_ack_n == 2'b11, "R10", "ack on deselect", int'(async_ack_n), 3);
    chk(lane_we == 4'b0, "R10", "lanes on deselect", int'(lane_we), 0);
    @(negedge clk);
    as_n = 1; ds_n = 1; ready = 0;
    repeat (2) @(negedge clk);

    // R11: strobe with no select starts nothing.
    sync_mode = 1; rd = 1; as_n = 0; ds_n = 0; ready = 1;
    repeat (5) @(negedge clk);
    chk(sync_ack_n && async_ack_n == 2'b11, "R11", "no termination unselected", int'(sync_ack_n), 1);
    as_n = 1; ds_n = 1; ready = 0;
    @(negedge clk);
    board_sel = 1;
    @(negedge clk);

    // R9: bus error while parked in the wait state.
    sync_mode = 1; rd = 0; sz = 2'b10; off = 2'b10; as_n = 0; ds_n = 0; ready = 0;
    repeat (3) @(negedge clk);
    chk(lane_we == 4'b0011, "R7", "lanes while waiting", int'(lane_we), 3);
    fault_n = 1'b0;
    #1;
    chk(lane_we == 4'b0 && sync_ack_n && async_ack_n == 2'b11, "R9", "release on error", int'(lane_we), 0);
    @(negedge clk);
    ready = 1;
    @(negedge clk);
    fault_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sync_ack_n && lane_we == 4'b0, "R9", "no termination after error", int'(sync_ack_n), 1);
    as_n = 1; ds_n = 1; ready = 0;
    repeat (3) @(negedge clk);

    chk(q.size() == 0, "R3", "expected items left", q.size(), 0);
  endtask

  initial begin
    fork
      stimulus();
      begin
        repeat (200000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) chk(1'b0, "R1", "watchdog expired", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule